// File: doc/BRIEF.md
# Two-Stage Priority DMA Channel Arbiter

This block decides which of N DMA channels may move its next data item. A channel is requesting when its hardware request line is high or its software trigger is high. Each channel also carries a 2-bit software priority. The arbiter picks the channel with the highest priority level. If several channels share that level, the channel with the smallest index wins. The winner gets a registered one-hot grant for exactly one single-item transfer.

The grant stays fixed until the transfer engine pulses `item_done`. In the cycle after that pulse no channel is granted. The next decision is taken in that idle cycle and shows on the grant in the cycle after it. A channel set for memory-to-memory transfers is therefore arbitrated again after every item. When such a channel has just finished an item and some other channel is requesting, it sits out the next decision. This lets lower-level channels interleave with a long block copy.

`grant_valid` and `item_done` form a simple handshake. The consumer sees a stable grant while `grant_valid` is high. It accepts the item by pulsing `item_done`. The grant has no back-pressure other than this: it waits as long as needed for `item_done`. An `item_done` that arrives while nothing is granted has no effect.

Top module: `dma_prio_arbiter`

## Requirements
- R1: Channel i is active when `hw_req[i]` or `sw_trig[i]` is high. Either source alone makes the channel eligible for a grant.
- R2: The priority of channel i is `prio[2i+1:2i]`, where 2'b11 is very high, 2'b10 is high, 2'b01 is medium and 2'b00 is low. An eligible channel at a higher level always wins over one at a lower level.
- R3: Among eligible channels at the same level, the channel with the lowest index wins.
- R4: `grant` is either all zeros or one-hot. `grant_valid` is high exactly when `grant` is nonzero. With no active channel, both stay low.
- R5: A grant is registered. It appears on the clock edge at which the arbiter is idle and sees an active channel. It then holds the same value until `item_done` is sampled high, even if requests or priorities change in the meantime.
- R6: A high `item_done` while granted clears the grant on that edge, so no grant is issued in that cycle. The earliest new grant follows one edge later. `item_done` while nothing is granted is ignored.
- R7: When a channel whose `mem2mem` bit is high at `item_done` completes an item, that channel is excluded from the next decision only. The exclusion applies only if another channel is active at that decision. Otherwise the channel may win again.
- R8: A channel whose request drops before a decision is not granted at that decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req | input | N | Hardware request per channel |
| sw_trig | input | N | Software trigger per channel |
| mem2mem | input | N | Channel is in memory-to-memory mode |
| prio | input | 2*N | 2-bit priority level per channel, channel i at bits 2i+1:2i |
| item_done | input | 1 | Single-cycle pulse: granted item completed |
| grant | output | N | One-hot grant, zero when idle |
| grant_valid | output | 1 | A grant is currently issued |

## Verification
The assertions check four things on every cycle:
- the grant is one-hot or empty, and it agrees with `grant_valid`;
- a grant is held until `item_done`;
- completion always leaves one cycle with no grant;
- a fresh grant goes only to a channel that was active one cycle earlier.

Level ordering, index tie-breaking and the one-decision exclusion after a memory-to-memory item depend on comparing several channels. Those are shown only by the bench scenarios. The bench compares the granted channel against expected winners for chosen request and priority patterns.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int PRIO_W     = 2;
  localparam int NUM_LEVELS = 1 << PRIO_W;

  typedef enum logic [PRIO_W-1:0] {
    PRIO_LOW   = 2'b00,
    PRIO_MED   = 2'b01,
    PRIO_HIGH  = 2'b10,
    PRIO_VHIGH = 2'b11
  } prio_lvl_e;

  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arb_state_e;
endpackage

// File: rtl/dma_arb_req_qual.sv
module dma_arb_req_qual #(
  parameter int N = 4
) (
  input  logic [N-1:0] hw_req,
  input  logic [N-1:0] sw_trig,
  input  logic [N-1:0] skip_mask,
  output logic [N-1:0] active,
  output logic [N-1:0] eligible
);
  logic [N-1:0] masked;

  // Either request source makes the channel active.
  assign active = hw_req | sw_trig;
  assign masked = active & ~skip_mask;

  // The skip applies only when another channel is left to serve.
  assign eligible = (masked != '0) ? masked : active;
endmodule

// File: rtl/dma_arb_prio_sel.sv
module dma_arb_prio_sel
  import dma_arb_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0]        eligible,
  input  logic [N*PRIO_W-1:0] prio,
  output logic [N-1:0]        winner,
  output logic                any_req
);
  logic [N-1:0]          lvl_match [NUM_LEVELS];
  logic [NUM_LEVELS-1:0] lvl_hit;
  logic [PRIO_W-1:0]     top_lvl;
  logic [N-1:0]          cand;

  // Stage one: for each level, mark the eligible channels set to it.
  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
    for (genvar i = 0; i < N; i++) begin : g_ch
      assign lvl_match[l][i] = eligible[i] && (prio[i*PRIO_W +: PRIO_W] == PRIO_W'(l));
    end
    assign lvl_hit[l] = |lvl_match[l];
  end

  // Pick the highest level that has at least one eligible channel.
  always_comb begin
    top_lvl = '0;
    for (int l = 0; l < NUM_LEVELS; l++) begin
      if (lvl_hit[l]) top_lvl = PRIO_W'(l);
    end
  end

  // Stage two: the lowest index among channels at that level wins.
  assign cand    = lvl_match[top_lvl];
  assign winner  = cand & (~cand + N'(1));
  assign any_req = |eligible;
endmodule

// File: rtl/dma_arb_grant_ctrl.sv
module dma_arb_grant_ctrl
  import dma_arb_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] winner,
  input  logic         any_req,
  input  logic         item_done,
  input  logic [N-1:0] mem2mem,
  output logic [N-1:0] grant,
  output logic         grant_valid,
  output logic [N-1:0] skip_mask
);
  arb_state_e   state_q;
  logic [N-1:0] grant_q;
  logic [N-1:0] skip_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      grant_q <= '0;
      skip_q  <= '0;
    end else begin
      unique case (state_q)
        ARB_IDLE: begin
          if (any_req) begin
            state_q <= ARB_BUSY;
            grant_q <= winner;
            skip_q  <= '0;
          end
        end
        ARB_BUSY: begin
          if (item_done) begin
            state_q <= ARB_IDLE;
            grant_q <= '0;
            skip_q  <= ((grant_q & mem2mem) != '0) ? grant_q : '0;
          end
        end
        default: state_q <= ARB_IDLE;
      endcase
    end
  end

  assign grant       = grant_q;
  assign grant_valid = (state_q == ARB_BUSY);
  assign skip_mask   = skip_q;
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_arb_pkg::*;
#(
  parameter int N = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        hw_req,
  input  logic [N-1:0]        sw_trig,
  input  logic [N-1:0]        mem2mem,
  input  logic [N*PRIO_W-1:0] prio,
  input  logic                item_done,
  output logic [N-1:0]        grant,
  output logic                grant_valid
);
  logic [N-1:0] active;
  logic [N-1:0] eligible;
  logic [N-1:0] skip_mask;
  logic [N-1:0] winner;
  logic         any_req;

  dma_arb_req_qual #(.N(N)) u_qual (
    .hw_req    (hw_req),
    .sw_trig   (sw_trig),
    .skip_mask (skip_mask),
    .active    (active),
    .eligible  (eligible)
  );

  dma_arb_prio_sel #(.N(N)) u_sel (
    .eligible (eligible),
    .prio     (prio),
    .winner   (winner),
    .any_req  (any_req)
  );

  dma_arb_grant_ctrl #(.N(N)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .winner      (winner),
    .any_req     (any_req),
    .item_done   (item_done),
    .mem2mem     (mem2mem),
    .grant       (grant),
    .grant_valid (grant_valid),
    .skip_mask   (skip_mask)
  );
endmodule

// File: rtl/dma_prio_arbiter_chk.sv
module dma_prio_arbiter_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] hw_req,
  input logic [N-1:0] sw_trig,
  input logic         item_done,
  input logic [N-1:0] grant,
  input logic         grant_valid
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R4

  AST_VALID_MATCHES_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid == (grant != '0)); // R4

  AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && (hw_req | sw_trig) == '0) |=> !grant_valid); // R4

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !item_done) |=> (grant_valid && $stable(grant))); // R5

  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && item_done) |=> !grant_valid); // R6

  AST_GRANT_TO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> ((grant & $past(hw_req | sw_trig)) != '0)); // R8
endmodule

bind dma_prio_arbiter dma_prio_arbiter_chk #(.N(N)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hw_req      (hw_req),
  .sw_trig     (sw_trig),
  .item_done   (item_done),
  .grant       (grant),
  .grant_valid (grant_valid)
);

// File: tb/dma_prio_arbiter_tb_top.sv
module dma_prio_arbiter_tb_top;
  localparam int N = 4;
  localparam int NV = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] hw_req, sw_trig, mem2mem;
  logic [2*N-1:0] prio;
  logic         item_done;
  logic [N-1:0] grant;
  logic         grant_valid;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  dma_prio_arbiter #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_trig(sw_trig),
    .mem2mem(mem2mem), .prio(prio), .item_done(item_done),
    .grant(grant), .grant_valid(grant_valid)
  );

  // {hw_req, sw_trig, prio, expected grant}
  localparam logic [19:0] VEC [NV] = '{
    {4'b0001, 4'b0000, 8'b00_00_00_00, 4'b0001}, // R1 hardware only
    {4'b0000, 4'b0100, 8'b00_00_00_00, 4'b0100}, // R1 software only
    {4'b1111, 4'b0000, 8'b00_00_00_00, 4'b0001}, // R3 all low
    {4'b1111, 4'b0000, 8'b11_00_00_00, 4'b1000}, // R2 very high on ch3
    {4'b0110, 4'b0000, 8'b00_10_10_00, 4'b0010}, // R3 tie at high
    {4'b1010, 4'b0101, 8'b10_10_01_01, 4'b0100}, // R2 R3 mixed sources
    {4'b1001, 4'b0000, 8'b01_00_00_00, 4'b1000}, // R2 medium over low
    {4'b0011, 4'b0000, 8'b00_00_11_10, 4'b0010}  // R2 very high over high
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [N-1:0] exp_g, logic exp_v);
    n_chk++;
    if (grant !== exp_g || grant_valid !== exp_v) begin
      n_fail++;
      $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%b",
               req, grant, grant_valid, exp_g, exp_v);
    end
  endtask

  task automatic finish_item();
    item_done = 1'b1;
    tick();
    item_done = 1'b0;
  endtask

  task automatic clear_req();
    hw_req = '0; sw_trig = '0; mem2mem = '0; prio = '0;
  endtask

  initial begin
    rst_n = 1'b0; item_done = 1'b0;
    clear_req();
    @(negedge clk);
    tick(); tick();
    chk("R4 reset", 4'b0000, 1'b0);
    rst_n = 1'b1;
    tick(); tick();
    chk("R4 no request idle", 4'b0000, 1'b0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      hw_req  = VEC[v][19:16];
      sw_trig = VEC[v][15:12];
      prio    = VEC[v][11:4];
      tick();
      chk($sformatf("R2/R3 vector %0d", v), VEC[v][3:0], 1'b1);
      clear_req();
      finish_item();
      chk("R6 release after vector", 4'b0000, 1'b0);
      tick();
    end

    // R5: grant held while a stronger request arrives and the owner drops
    hw_req = 4'b0100; prio = '0;
    tick();
    chk("R5 initial grant", 4'b0100, 1'b1);
    hw_req = 4'b0101; prio = 8'b00_00_00_11;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R5 held against very high", 4'b0100, 1'b1);
    end
    hw_req = 4'b0001;
    tick();
    chk("R5 held after request drop", 4'b0100, 1'b1);
    finish_item();
    chk("R6 no grant in release cycle", 4'b0000, 1'b0);
    tick();
    chk("R6 next grant one edge later", 4'b0001, 1'b1);
    clear_req();
    finish_item();
    tick();

    // R6: item_done while idle is ignored
    finish_item();
    chk("R6 idle done ignored", 4'b0000, 1'b0);
    hw_req = 4'b0010;
    tick();
    chk("R6 normal grant after idle done", 4'b0010, 1'b1);
    clear_req();
    finish_item();
    tick();

    // R8: request raised and dropped while busy is skipped
    hw_req = 4'b0001;
    tick();
    chk("R8 owner granted", 4'b0001, 1'b1);
    hw_req = 4'b0011;
    tick();
    hw_req = 4'b0000;
    tick();
    finish_item();
    tick();
    chk("R8 dropped request not granted", 4'b0000, 1'b0);

    // R7: memory-to-memory channel interleaves with a low channel
    hw_req = 4'b1001; mem2mem = 4'b0001; prio = 8'b00_00_00_11;
    tick();
    chk("R7 m2m first grant", 4'b0001, 1'b1);
    finish_item();
    chk("R7 release", 4'b0000, 1'b0);
    tick();
    chk("R7 low channel interleaved", 4'b1000, 1'b1);
    finish_item();
    tick();
    chk("R7 mask for one decision only", 4'b0001, 1'b1);
    hw_req = 4'b0001;
    finish_item();
    tick();
    chk("R7 sole m2m requester regranted", 4'b0001, 1'b1);
    clear_req();
    finish_item();
    tick();
    chk("R4 idle at end", 4'b0000, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog: expected=finish actual=timeout");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule